// File: doc/BRIEF.md
# Charge Watchdog Timer Controller

This block stops a battery charger from running on stale settings when the host goes quiet. It receives one strobe for each write to the charge-voltage register, one for each write to the charge-current register, and one for each write to the option register, together with the 2-bit timeout field carried in that option write. A slow periodic tick (for example one per millisecond) advances an internal count. If the count reaches the selected period with no refresh, the block withdraws its charge-allow output and raises a timeout flag.

The register storage and the bus protocol sit outside this block. Expiry leaves every register as it was; only the charge-allow decision changes. Charging comes back when the host rewrites the voltage or current setting, or when it turns the watchdog off through the option field. The number of ticks per second is a parameter, so a test can run with a short timebase.

Top module: `chg_wdog_top`

## Requirements
- R1: After reset, allow_o is 1, expired_o is 0, and the selected timeout is 175 s (field value 2'b11).
- R2: Timeout field encoding: 2'b00 = off, 2'b01 = 44 s, 2'b10 = 88 s, 2'b11 = 175 s; a period of S seconds expires on the clock edge that samples the (S x TICKS_PER_SEC)-th tick since the last restart, and expired_o and allow_o change on that edge.
- R3: A charge-voltage or charge-current write strobe restarts the count from zero.
- R4: Once expired, expired_o stays 1 and allow_o stays 0 while further ticks arrive and no resume write is seen.
- R5: While expired, a charge-voltage or charge-current write clears expired_o and sets allow_o on the next edge, and a full new period then runs from zero.
- R6: While expired, an option write with field 2'b00 resumes charging on the next edge; an option write with a nonzero field does not resume.
- R7: An option write that changes the timeout field restarts the count from zero; an option write repeating the current field leaves the count running.
- R8: With the field at 2'b00, expired_o never rises, however many ticks arrive.
- R9: A refresh write in the same cycle as the final tick wins: no expiry occurs and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase pulse |
| wr_vchg_i | input | 1 | Charge-voltage register write strobe |
| wr_ichg_i | input | 1 | Charge-current register write strobe |
| wr_opt_i | input | 1 | Option register write strobe |
| opt_sel_i | input | 2 | Timeout field of the option write, valid with wr_opt_i |
| allow_o | output | 1 | Charging permitted |
| expired_o | output | 1 | Watchdog has expired |

## Verification
A count that drifts or fails to clear shows up as expiry one or more ticks early or late, so the bench probes each period at its last quiet tick and at the expiring tick. A stale copy of the timeout field shows as the wrong period length after an option write, or as a suspension that a write of the off code fails to lift within one clock. A wrong suspension state appears at allow_o and expired_o on the very edge after the event that should have changed it.

// File: rtl/chg_wdog_pkg.sv
package chg_wdog_pkg;
  typedef enum logic [1:0] {
    WD_OFF   = 2'b00,
    WD_SHORT = 2'b01,
    WD_MID   = 2'b10,
    WD_LONG  = 2'b11
  } wd_sel_e;

  localparam wd_sel_e WD_RESET_SEL = WD_LONG;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_SUSP = 1'b1
  } wd_state_e;
endpackage

// File: rtl/chg_wdog_sel.sv
module chg_wdog_sel
  import chg_wdog_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned SEC_SHORT     = 44,
  parameter int unsigned SEC_MID       = 88,
  parameter int unsigned SEC_LONG      = 175,
  parameter int unsigned CNT_W         = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_opt_i,
  input  logic [1:0]       opt_sel_i,
  output logic             changed_o,
  output logic             enabled_o,
  output logic [CNT_W-1:0] limit_o
);
  localparam int unsigned SEC_TAB [4] = '{0, SEC_SHORT, SEC_MID, SEC_LONG};

  wd_sel_e sel_q, sel_d;
  logic [CNT_W-1:0] lim_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'(SEC_TAB[g] * TICKS_PER_SEC);
  end

  always_comb begin
    sel_d = sel_q;
    if (wr_opt_i) sel_d = wd_sel_e'(opt_sel_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= WD_RESET_SEL;
    else         sel_q <= sel_d;
  end

  assign changed_o = wr_opt_i && (wd_sel_e'(opt_sel_i) != sel_q);
  assign enabled_o = (sel_q != WD_OFF);
  assign limit_o   = lim_tab[sel_q];
endmodule

// File: rtl/chg_wdog_cnt.sv
module chg_wdog_cnt #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit_o = inc_i && !clr_i && (cnt_q == limit_i - CNT_W'(1));
endmodule

// File: rtl/chg_wdog_fsm.sv
module chg_wdog_fsm
  import chg_wdog_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic resume_i,
  output logic susp_o
);
  wd_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (hit_i)    st_d = ST_SUSP;
      ST_SUSP: if (resume_i) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign susp_o = (st_q == ST_SUSP);
endmodule

// File: rtl/chg_wdog_top.sv
module chg_wdog_top
  import chg_wdog_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned SEC_SHORT     = 44,
  parameter int unsigned SEC_MID       = 88,
  parameter int unsigned SEC_LONG      = 175
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_vchg_i,
  input  logic       wr_ichg_i,
  input  logic       wr_opt_i,
  input  logic [1:0] opt_sel_i,
  output logic       allow_o,
  output logic       expired_o
);
  localparam int unsigned MAX_SEC =
    (SEC_LONG > SEC_MID) ? ((SEC_LONG > SEC_SHORT) ? SEC_LONG : SEC_SHORT)
                         : ((SEC_MID > SEC_SHORT) ? SEC_MID : SEC_SHORT);
  localparam int unsigned CNT_W = $clog2(MAX_SEC * TICKS_PER_SEC + 1);

  logic             sel_changed, enabled, hit, susp;
  logic             refresh, restart, resume, inc;
  logic [CNT_W-1:0] limit;

  assign refresh = wr_vchg_i | wr_ichg_i;
  assign restart = refresh | sel_changed;
  assign resume  = refresh | (wr_opt_i && (wd_sel_e'(opt_sel_i) == WD_OFF));
  assign inc     = tick_i && enabled && !susp && !restart;

  chg_wdog_sel #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .SEC_SHORT(SEC_SHORT),
    .SEC_MID(SEC_MID), .SEC_LONG(SEC_LONG), .CNT_W(CNT_W)
  ) sel_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_opt_i(wr_opt_i), .opt_sel_i(opt_sel_i),
    .changed_o(sel_changed), .enabled_o(enabled), .limit_o(limit)
  );

  chg_wdog_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(restart), .inc_i(inc),
    .limit_i(limit), .hit_o(hit)
  );

  chg_wdog_fsm fsm_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .resume_i(resume), .susp_o(susp)
  );

  assign expired_o = susp;
  assign allow_o   = !susp;
endmodule

// File: rtl/chg_wdog_chk.sv
module chg_wdog_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_vchg_i,
  input logic       wr_ichg_i,
  input logic       wr_opt_i,
  input logic [1:0] opt_sel_i,
  input logic       allow_o,
  input logic       expired_o
);
  logic [1:0] sel_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_sh <= 2'b11;
    else if (wr_opt_i) sel_sh <= opt_sel_i;
  end

  assert_quiet_no_expire_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!expired_o && !tick_i) |=> !expired_o);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !wr_vchg_i && !wr_ichg_i && !(wr_opt_i && opt_sel_i == 2'b00))
      |=> (expired_o && !allow_o));

  assert_resume_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && (wr_vchg_i || wr_ichg_i)) |=> (allow_o && !expired_o));

  assert_off_resume_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && wr_opt_i && opt_sel_i == 2'b00) |=> !expired_o);

  assert_off_never_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_sh == 2'b00) |-> !expired_o);

  assert_refresh_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!expired_o && (wr_vchg_i || wr_ichg_i)) |=> !expired_o);
endmodule

bind chg_wdog_top chg_wdog_chk chk_i (.*);

// File: tb/chg_wdog_tb.sv
module chg_wdog_top_tb_top;
  localparam int TPS     = 2;
  localparam int L_SHORT = 44 * TPS;
  localparam int L_MID   = 88 * TPS;
  localparam int L_LONG  = 175 * TPS;

  typedef struct {
    logic  exp_expired;
    string tag;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, wr_vchg_i = 1'b0, wr_ichg_i = 1'b0, wr_opt_i = 1'b0;
  logic [1:0] opt_sel_i = 2'b00;
  logic allow_o, expired_o;

  int checks = 0, errors = 0, cycles = 0;
  exp_item_t sb_q[$];

  always #2 clk = ~clk;

  chg_wdog_top #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_vchg_i(wr_vchg_i),
    .wr_ichg_i(wr_ichg_i), .wr_opt_i(wr_opt_i), .opt_sel_i(opt_sel_i),
    .allow_o(allow_o), .expired_o(expired_o)
  );

  task automatic cyc(input logic t, input logic v, input logic i,
                     input logic o, input logic [1:0] s);
    tick_i = t; wr_vchg_i = v; wr_ichg_i = i; wr_opt_i = o; opt_sel_i = s;
    @(negedge clk);
    tick_i = 0; wr_vchg_i = 0; wr_ichg_i = 0; wr_opt_i = 0; opt_sel_i = 2'b00;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cyc(1, 0, 0, 0, 2'b00);
  endtask

  task automatic expect_st(input logic e, input string tag);
    exp_item_t it;
    it.exp_expired = e;
    it.tag = tag;
    sb_q.push_back(it);
    #0;
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      begin
        exp_item_t it;
        it = sb_q.pop_front();
        checks++;
        if (expired_o !== it.exp_expired || allow_o !== !it.exp_expired) begin
          errors++;
          $display("FAIL %s: expired=%b allow=%b, expected expired=%b allow=%b",
                   it.tag, expired_o, allow_o, it.exp_expired, !it.exp_expired);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_st(0, "R1 reset state");
    rst_ni = 1'b1;
    @(negedge clk);
    // default 175 s period
    ticks(L_LONG - 1); expect_st(0, "R1 default period, last quiet tick");
    ticks(1);          expect_st(1, "R2 R1 expiry at 175 s");
    ticks(10);         expect_st(1, "R4 stays expired under ticks");
    cyc(0, 1, 0, 0, 2'b00); expect_st(0, "R5 voltage write resumes");
    ticks(L_LONG - 1); expect_st(0, "R5 full period after resume");
    ticks(1);          expect_st(1, "R5 expiry after resume period");
    cyc(0, 0, 1, 0, 2'b00); expect_st(0, "R5 current write resumes");
    ticks(200);
    cyc(0, 1, 0, 0, 2'b00); // R3 refresh mid-count
    ticks(L_LONG - 1); expect_st(0, "R3 refresh restarted count");
    ticks(1);          expect_st(1, "R3 expiry one period after refresh");
    cyc(0, 0, 0, 1, 2'b01); expect_st(1, "R6 nonzero option write keeps suspension");
    cyc(0, 0, 0, 1, 2'b00); expect_st(0, "R6 off code resumes");
    ticks(L_LONG + 50); expect_st(0, "R8 off never expires");
    cyc(0, 0, 0, 1, 2'b01);
    ticks(L_SHORT - 1); expect_st(0, "R2 44 s last quiet tick");
    ticks(1);           expect_st(1, "R2 44 s expiry");
    cyc(0, 0, 1, 0, 2'b00); expect_st(0, "R5 resume for R7 test");
    ticks(50);
    cyc(0, 0, 0, 1, 2'b01); // same value: no restart
    ticks(L_SHORT - 51); expect_st(0, "R7 same field, count kept");
    ticks(1);            expect_st(1, "R7 same field, expiry on original schedule");
    cyc(0, 0, 1, 0, 2'b00);
    ticks(50);
    cyc(0, 0, 0, 1, 2'b10); // changed: restart with 88 s
    ticks(L_MID - 1); expect_st(0, "R7 R2 changed field restarts, 88 s quiet");
    ticks(1);         expect_st(1, "R2 88 s expiry");
    cyc(0, 1, 0, 0, 2'b00); expect_st(0, "R5 resume for R9 test");
    ticks(L_MID - 1);
    cyc(1, 1, 0, 0, 2'b00); expect_st(0, "R9 refresh beats final tick");
    ticks(L_MID - 1); expect_st(0, "R9 count restarted from zero");
    ticks(1);         expect_st(1, "R9 expiry one period later");
    @(negedge clk);
    wait (sb_q.size() == 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule